// File: doc/BRIEF.md
# I2C Target Front End for a Serial Byte Memory

This block sits between a two-wire I2C bus and a byte-wide non-volatile memory array of 2 to 16 Kbit. It runs on a fast system clock and oversamples the bus. Both bus lines pass through a two-flop synchroniser and a digital glitch filter. The block then detects start and stop conditions and behaves as a bus target. It decodes the device byte, takes a byte address and serves four kinds of transfer: page write, current-address read, random read and sequential read. It drives SDA only as an open-drain pull-down, through `sda_oe`.

On the memory side the block loads each received data byte into an external page buffer with a one-cycle strobe. It requests a commit of that buffer when the write transfer ends. It reads stored bytes through a synchronous read port that gives data one clock after the address. Whether the memory is busy with a commit is reported by `mem_busy`. While it is high the target does not acknowledge its device byte, so a bus master can poll for completion.

The controller has nine named states:
- `ST_IDLE`: ignores the bus until a start.
- `ST_DEV`: shifts in the device byte.
- `ST_DEV_ACK`: drives the acknowledge for the device byte.
- `ST_ADR`: shifts in the byte address.
- `ST_ADR_ACK`: acknowledges the byte address.
- `ST_WR`: shifts in a data byte.
- `ST_WR_ACK`: acknowledges the data byte.
- `ST_RD`: shifts out a data byte.
- `ST_RD_ACK`: samples the master's acknowledge.

The transitions are:
- A start moves any state to `ST_DEV`.
- A stop moves any state to `ST_IDLE`.
- `ST_DEV` goes to `ST_DEV_ACK` on a match, or to `ST_IDLE` on a mismatch or while busy.
- `ST_DEV_ACK` goes to `ST_RD` for a read or to `ST_ADR` for a write.
- `ST_ADR` goes to `ST_ADR_ACK`, then to `ST_WR`.
- `ST_WR` and `ST_WR_ACK` alternate.
- `ST_RD` goes to `ST_RD_ACK`. From there it returns to `ST_RD` on an acknowledge, or goes to `ST_IDLE` on a no-acknowledge.

Top module: `smem_i2c_target`

## Requirements
- R1: After reset `sda_oe`, `ld_en` and `commit` are low, and the internal address pointer is 0.
- R2: A device byte is accepted only if bits [7:4] are 1010 and each bit of [3:1] above the lowest E bits equals the matching `dev_pins` bit, where E = log2(MEM_BYTES) - 8. Bit 0 set to 1 selects a read. A rejected byte gets no acknowledge, and the bus is ignored until the next start.
- R3: The target acknowledges the byte address and every written data byte by holding `sda_oe` high for the 9th clock. Each data byte appears once on `ld_data` with its address on `ld_addr`, during a one-cycle `ld_en` pulse.
- R4: Data bits are taken on the rising edge of filtered SCL. `sda_oe` changes only while filtered SCL is low, except when a start or stop releases it.
- R5: Read data leaves MSB first. `sda_oe` is released during the 9th clock. An acknowledge from the master starts the next byte; a no-acknowledge leaves SDA released until the next start or stop.
- R6: During a write the pointer advances only in its low log2(PAGE_BYTES) bits, so more data than a page wraps to the page start and overwrites earlier bytes. The last load wins.
- R7: During a read the pointer advances over the whole memory and wraps from MEM_BYTES-1 to 0.
- R8: A single `commit` pulse follows the stop or repeated start that ends a write carrying at least one full data byte. Reads, address-only writes and rejected bytes produce none.
- R9: While `mem_busy` is high, a matching device byte is not acknowledged.
- R10: A start or stop in any state abandons the current transfer and drops any partial byte.
- R11: Pulses shorter than FILT_CYC clocks on SCL or SDA have no effect.
- R12: The byte address phase sets the pointer to {device-byte address bits, byte address}. A read device byte uses the current pointer and ignores its own address bits. After every byte the pointer points one past that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_pins | input | 3 | Strapped device address bits |
| mem_busy | input | 1 | Memory is committing a page |
| ld_en | output | 1 | One-cycle load strobe into the page buffer |
| ld_addr | output | log2(MEM_BYTES) | Byte address for the load |
| ld_data | output | 8 | Byte to load |
| commit | output | 1 | One-cycle request to write the page buffer |
| rd_addr | output | log2(MEM_BYTES) | Read port address (current pointer) |
| rd_data | input | 8 | Read port data, valid one clock after `rd_addr` |

## Verification
The bench builds the block with MEM_BYTES=512, PAGE_BYTES=16 and FILT_CYC=4. This gives exactly one address bit carried in the device byte and two bits compared against the pins, so both the comparison path and the address-extension path of R2 and R12 are exercised. The small memory makes end-of-memory read wrap cheap to reach. A short filter lets 2-clock glitches be injected against a 10-clock bus quarter period. The bench's memory model holds `mem_busy` high for 1500 clocks after a commit, which leaves room to poll during the busy window.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADR,
        ST_ADR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } st_t;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/smem_line_filter.sv
module smem_line_filter #(
    parameter int FILT_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= din;
            s2 <= s1;
        end
    end

    // output follows the synchronised line only after it has differed for FILT_CYC clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= 1'b1;
            cnt  <= '0;
        end else if (s2 == dout) begin
            cnt <= '0;
        end else if (cnt == CW'(FILT_CYC - 1)) begin
            dout <= s2;
            cnt  <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/smem_bus_events.sv
module smem_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/smem_i2c_target.sv
module smem_i2c_target #(
    parameter int MEM_BYTES  = 2048,
    parameter int PAGE_BYTES = 16,
    parameter int FILT_CYC   = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_in,
    input  logic                         sda_in,
    output logic                         sda_oe,
    input  logic [2:0]                   dev_pins,
    input  logic                         mem_busy,
    output logic                         ld_en,
    output logic [$clog2(MEM_BYTES)-1:0] ld_addr,
    output logic [7:0]                   ld_data,
    output logic                         commit,
    output logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    input  logic [7:0]                   rd_data
);
    import smem_pkg::*;

    localparam int            AW       = $clog2(MEM_BYTES);
    localparam int            EXT      = AW - 8;
    localparam int            PW       = $clog2(PAGE_BYTES);
    localparam logic [2:0]    PIN_MASK = 3'(3'b111 << EXT);
    localparam logic [AW-1:0] PG_MASK  = AW'(PAGE_BYTES - 1);

    // ---- input conditioning, one filter per bus line ----
    logic [1:0] raw, filt;
    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        smem_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .dout (filt[g])
        );
    end

    logic scl_f, sda_f;
    assign scl_f = filt[1];
    assign sda_f = filt[0];

    logic scl_rise, scl_fall, start_evt, stop_evt;

    smem_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    // ---- controller state ----
    st_t           st, st_nx;
    logic [7:0]    sh;
    logic [3:0]    bitcnt;
    logic [2:0]    dev_hi;
    logic          dev_rw;
    logic [AW-1:0] ptr;
    logic          acked;
    logic          dirty;

    logic rx_done, dev_ok;
    assign rx_done = scl_fall && (bitcnt == 4'd8);
    assign dev_ok  = (sh[7:4] == DEV_PREFIX) &&
                     (((sh[3:1] ^ dev_pins) & PIN_MASK) == 3'b000) &&
                     !mem_busy;

    logic [AW-1:0] ptr_page_inc, ptr_lin_inc, ptr_load;
    assign ptr_lin_inc  = ptr + AW'(1);
    assign ptr_page_inc = (ptr & ~PG_MASK) | (ptr_lin_inc & PG_MASK);
    assign ptr_load     = AW'({dev_hi & ~PIN_MASK, sh});

    assign rd_addr = ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (start_evt) begin
            st_nx = ST_DEV;
        end else if (stop_evt) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:    st_nx = ST_IDLE;
                ST_DEV:     if (rx_done)  st_nx = dev_ok ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK: if (scl_fall) st_nx = dev_rw ? ST_RD : ST_ADR;
                ST_ADR:     if (rx_done)  st_nx = ST_ADR_ACK;
                ST_ADR_ACK: if (scl_fall) st_nx = ST_WR;
                ST_WR:      if (rx_done)  st_nx = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall) st_nx = ST_WR;
                ST_RD:      if (scl_fall && bitcnt == 4'd7) st_nx = ST_RD_ACK;
                ST_RD_ACK:  if (scl_fall) st_nx = acked ? ST_RD : ST_IDLE;
                default:    st_nx = ST_IDLE;
            endcase
        end
    end

    // ---- datapath and outputs ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe  <= 1'b0;
            ld_en   <= 1'b0;
            ld_addr <= '0;
            ld_data <= '0;
            commit  <= 1'b0;
            sh      <= '0;
            bitcnt  <= '0;
            dev_hi  <= '0;
            dev_rw  <= 1'b0;
            ptr     <= '0;
            acked   <= 1'b0;
            dirty   <= 1'b0;
        end else begin
            ld_en  <= 1'b0;
            commit <= 1'b0;
            if (start_evt || stop_evt) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                commit <= dirty;
                dirty  <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: ;
                    ST_DEV, ST_ADR, ST_WR: begin
                        if (scl_rise) begin
                            sh     <= {sh[6:0], sda_f};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (rx_done) begin
                            bitcnt <= '0;
                            if (st == ST_DEV) begin
                                dev_hi <= sh[3:1];
                                dev_rw <= sh[0];
                                sda_oe <= dev_ok;
                            end else if (st == ST_ADR) begin
                                ptr    <= ptr_load;
                                sda_oe <= 1'b1;
                            end else begin
                                ld_en   <= 1'b1;
                                ld_addr <= ptr;
                                ld_data <= sh;
                                ptr     <= ptr_page_inc;
                                dirty   <= 1'b1;
                                sda_oe  <= 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (dev_rw) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_ADR_ACK, ST_WR_ACK: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr_lin_inc;
                            end else begin
                                sh     <= {sh[6:0], 1'b0};
                                sda_oe <= ~sh[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) acked <= ~sda_f;
                        if (scl_fall && acked) begin
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            bitcnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smem_i2c_target_chk.sv
module smem_i2c_target_chk #(
    parameter int AW = 11,
    parameter int PW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           scl_f,
    input logic           start_evt,
    input logic           stop_evt,
    input smem_pkg::st_t  st,
    input logic           sda_oe,
    input logic           ld_en,
    input logic [AW-1:0]  ld_addr,
    input logic           commit,
    input logic [AW-1:0]  rd_addr,
    input logic           mem_busy
);
    import smem_pkg::*;

    localparam logic [AW-1:0] PM = AW'((1 << PW) - 1);

    // R4: the pull-down moves only with SCL low, unless a bus condition releases it
    a_r4_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!scl_f || $past(start_evt) || $past(stop_evt)));

    // R8: a commit follows only a start or stop
    a_r8_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(start_evt) || $past(stop_evt)));

    // R6: after a load the pointer moved inside its page
    a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (((rd_addr & ~PM) == ($past(ld_addr) & ~PM)) &&
                   ((rd_addr & PM) == (($past(ld_addr) + AW'(1)) & PM))));

    // R9: no acknowledge of the device byte while the memory is busy
    a_r9_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEV_ACK && $rose(sda_oe)) |-> !$past(mem_busy));

    // R3: each load coincides with the data acknowledge
    a_r3_load_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> (sda_oe && st == ST_WR_ACK));

    // R5: SDA released while the master answers a read byte
    a_r5_release_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD_ACK) |-> !sda_oe);

    // R8: load and commit strobes never overlap
    a_r8_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_en, commit}));
endmodule

bind smem_i2c_target smem_i2c_target_chk #(.AW(AW), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .st       (st),
    .sda_oe   (sda_oe),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .commit   (commit),
    .rd_addr  (rd_addr),
    .mem_busy (mem_busy)
);

// File: tb/smem_i2c_target_bench.sv
`timescale 1ns/1ps
module smem_i2c_target_bench;
    localparam int MEM  = 512;
    localparam int PAGE = 16;
    localparam int FILT = 4;
    localparam int AW   = 9;
    localparam int Q    = 10;
    localparam int BUSY = 1500;
    localparam logic [2:0] PINS = 3'b101;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          scl_m, sda_m;
    logic          sda_oe, ld_en, commit, mem_busy;
    logic [AW-1:0] ld_addr, rd_addr;
    logic [7:0]    ld_data, rd_data;
    logic          sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    smem_i2c_target #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .FILT_CYC(FILT)) u_smem_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
        .dev_pins(PINS), .mem_busy(mem_busy), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .commit(commit), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] init_pat(int i);
        return 8'((i * 37 + 11) ^ (i >> 8));
    endfunction

    // ---- memory model: page buffer, array, busy timer ----
    logic [7:0] mem    [MEM];
    logic [7:0] pend_d [MEM];
    logic       pend_v [MEM];
    int         busy_cnt;
    int         n_commit;
    assign mem_busy = (busy_cnt != 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM; i++) begin
                mem[i]    <= init_pat(i);
                pend_v[i] <= 1'b0;
            end
            busy_cnt <= 0;
            n_commit <= 0;
            rd_data  <= 8'h00;
        end else begin
            rd_data <= mem[rd_addr];
            if (ld_en) begin
                pend_d[ld_addr] <= ld_data;
                pend_v[ld_addr] <= 1'b1;
            end
            if (commit) begin
                for (int i = 0; i < MEM; i++)
                    if (pend_v[i]) begin
                        mem[i]    <= pend_d[i];
                        pend_v[i] <= 1'b0;
                    end
                busy_cnt <= BUSY;
                n_commit <= n_commit + 1;
            end else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    // ---- expected state ----
    logic [7:0] exp_mem [MEM];
    int         exp_ptr;
    int         n_chk, n_fail;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int page_inc(int p);
        return (p & ~(PAGE - 1)) | ((p + 1) & (PAGE - 1));
    endfunction

    function automatic logic [7:0] dev_byte(int addr, bit rw);
        return {4'b1010, PINS[2:1], 1'(addr >> 8), rw};
    endfunction

    // ---- bus master tasks ----
    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b0; wq(2*Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        ack = (sda_bus == 1'b0);
        wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    // sends a byte with a short SDA dip while SCL is high and a short SCL pulse while low (R11)
    task automatic send_byte_glitchy(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(Q);
            if (b[i]) begin sda_m = 1'b0; wq(2); sda_m = 1'b1; wq(Q-2); end
            else wq(Q);
            scl_m = 1'b0; wq(Q/2);
            if (i == 4) begin scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q/2-2); end
            else wq(Q/2);
        end
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        ack = (sda_bus == 1'b0);
        wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        d = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
            d[i] = sda_bus;
            wq(Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = ~give_ack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
        sda_m = 1'b1; wq(Q);
    endtask

    // ---- transactions with model update ----
    task automatic do_write(input int addr, input int n);
        bit ack;
        logic [7:0] d;
        int p;
        bus_start();
        send_byte(dev_byte(addr, 1'b0), ack);
        chk(ack, "R2 device byte write ack", int'(ack), 1);
        send_byte(8'(addr), ack);
        chk(ack, "R3 address byte ack", int'(ack), 1);
        p = addr;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            chk(ack, "R3 data byte ack", int'(ack), 1);
            exp_mem[p] = d;
            p = page_inc(p);
        end
        bus_stop();
        exp_ptr = p;
    endtask

    task automatic read_n(input int n, input string tag);
        logic [7:0] d;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            chk(d == exp_mem[exp_ptr], tag, int'(d), int'(exp_mem[exp_ptr]));
            exp_ptr = (exp_ptr + 1) % MEM;
        end
        chk(sda_oe == 1'b0, "R5 released after no-ack", int'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic do_rand_read(input int addr, input int n);
        bit ack;
        bus_start();
        send_byte(dev_byte(addr, 1'b0), ack);
        chk(ack, "R12 dummy write ack", int'(ack), 1);
        send_byte(8'(addr), ack);
        chk(ack, "R12 dummy address ack", int'(ack), 1);
        bus_start();
        send_byte(dev_byte(0, 1'b1), ack);
        chk(ack, "R12 read device ack", int'(ack), 1);
        exp_ptr = addr;
        read_n(n, "R7 random/sequential read data");
    endtask

    task automatic do_cur_read(input int n, input int hi_bit);
        bit ack;
        bus_start();
        send_byte(dev_byte(hi_bit << 8, 1'b1), ack);
        chk(ack, "R12 current read ack", int'(ack), 1);
        read_n(n, "R12 current-address read data");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        bit ack;
        int c0;
        logic [7:0] d;
        n_chk = 0; n_fail = 0;
        void'($urandom(32'd2024));
        for (int i = 0; i < MEM; i++) exp_mem[i] = init_pat(i);
        exp_ptr = 0;
        scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
        wq(5); rst_n = 1'b1; wq(5);

        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);
        chk(ld_en == 1'b0,  "R1 ld_en after reset",  int'(ld_en), 0);
        chk(commit == 1'b0, "R1 commit after reset", int'(commit), 0);
        do_cur_read(1, 1);   // R1 pointer 0; R12 address bit of read byte ignored

        // R3 byte write in the upper half, then R12 random read back
        do_write(9'h1F5, 1);
        chk(n_commit == 1, "R8 commit after write", n_commit, 1);
        // R9 polling during busy
        bus_start();
        send_byte(dev_byte(0, 1'b0), ack);
        chk(!ack, "R9 no ack while busy", int'(ack), 0);
        bus_stop();
        wq(BUSY + 100);
        c0 = n_commit;
        bus_start();
        send_byte(dev_byte(0, 1'b0), ack);
        chk(ack, "R9 ack after busy", int'(ack), 1);
        bus_stop();
        wq(20);
        chk(n_commit == c0, "R8 no commit without data", n_commit, c0);
        do_rand_read(9'h1F4, 3);
        chk(n_commit == c0, "R8 no commit for read", n_commit, c0);

        // R6 page wrap: 18 bytes into page 0x100
        do_write(9'h10E, 18);
        wq(BUSY + 100);
        do_cur_read(1, 0);   // R6 pointer one past, inside page
        do_rand_read(9'h100, 16);

        // R7 wrap at end of memory
        do_rand_read(9'h1FE, 4);

        // R2 mismatched pins and prefix
        bus_start();
        send_byte({4'b1010, ~PINS[2:1], 2'b00}, ack);
        chk(!ack, "R2 pin mismatch no ack", int'(ack), 0);
        send_byte(8'h00, ack);
        chk(!ack, "R2 ignored until start", int'(ack), 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, PINS[2:1], 2'b00}, ack);
        chk(!ack, "R2 prefix mismatch no ack", int'(ack), 0);
        bus_stop();

        // R10 start inside a partial device byte, then a valid read
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        do_cur_read(2, 0);

        // R10 stop inside a partial data byte
        bus_start();
        send_byte(dev_byte(9'h0A3, 1'b0), ack);
        send_byte(8'hA3, ack);
        d = 8'($urandom);
        send_byte(d, ack);
        exp_mem[9'h0A3] = d;
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_stop();
        exp_ptr = 9'h0A4;
        wq(BUSY + 100);
        do_rand_read(9'h0A3, 2);   // R10 only the full byte stored

        // R11 glitches ignored
        bus_start();
        send_byte(dev_byte(9'h033, 1'b0), ack);
        send_byte(8'h33, ack);
        send_byte_glitchy(8'hA5, ack);
        chk(ack, "R11 glitchy byte acked", int'(ack), 1);
        bus_stop();
        exp_mem[9'h033] = 8'hA5;
        wq(BUSY + 100);
        do_rand_read(9'h033, 1);

        // random mix
        for (int t = 0; t < 12; t++) begin
            int kind, a, n;
            kind = int'($urandom % 3);
            a = int'($urandom % MEM);
            n = 1 + int'($urandom % 4);
            if (kind == 0) begin
                do_write(a, n);
                wq(BUSY + 100);
            end else if (kind == 1) begin
                do_rand_read(a, n);
            end else begin
                do_cur_read(n, int'($urandom % 2));
            end
        end

        summary();
        $finish;
    end
endmodule